// File: doc/BRIEF.md
# Self-Clocked Serial Result Transmitter

This block sends a stored 16-bit conversion result over a two-wire serial output when the converter generates its own data clock. A conversion-start strobe arms the block. After a fixed wait it drives a burst of exactly sixteen pulses on its own data-clock output and shifts the held word out on the data line, most significant bit first. The word sent is always the one that was held when the strobe arrived, which is the result of the conversion before the one now starting.

Once the last bit has gone, the data line returns to the level of a tag input. That level is captured on the same clock edge that accepts the strobe. The line then keeps that level until the next burst, so a chain of converters can insert a separator bit between words. A format select picks the output coding: straight binary leaves the word unchanged, and two's complement inverts its top bit. The start wait and the half-period of the data clock are counted in cycles of the system clock. A one-cycle done pulse marks the end of each burst.

Top module: `intclk_result_tx`

## Requirements
- R1: While reset is asserted and on the first cycle after it, the data clock, data line, done and busy outputs are all 0, and the held word is 0.
- R2: Every accepted start strobe produces exactly WORD_W (16) rising edges on the data clock, and no more until the next accepted strobe.
- R3: The first rising edge of the data clock comes START_DLY system-clock cycles after the edge that samples the strobe. The clock then stays high for HALF_PER cycles and low for HALF_PER cycles, so successive rising edges are 2*HALF_PER cycles apart.
- R4: Bits leave most significant first. Each bit is already on the data line in the cycle before its rising edge, and it holds through the whole high phase. It changes only when the clock falls.
- R5: After the last falling edge the data line shows the tag level sampled at the strobe edge. It keeps that level until the next accepted strobe, whatever the tag input does in the meantime.
- R6: With fmt_sb_i = 1 the word is sent unchanged (straight binary). With fmt_sb_i = 0 bit 15 is inverted, so held 0x8000 is sent as 0x0000, 0xFFFF as 0x7FFF and 0x0000 as 0x8000. The select is sampled at the strobe edge.
- R7: A pulse on res_load_i stores res_word_i as the held word. A burst sends the word held before its strobe edge. A load on that same edge, or during the burst, appears only in the next burst.
- R8: A start strobe that arrives while a burst is pending or running is ignored. It neither restarts nor lengthens the burst, and it does not start another one afterwards.
- R9: done_o is high for exactly one cycle, on the edge of the last falling data-clock edge. On that same edge busy_o drops.
- R10: The data clock is low whenever busy_o is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| conv_start_i | input | 1 | Conversion-start strobe, one cycle high |
| res_load_i | input | 1 | Stores res_word_i as the held result |
| res_word_i | input | WORD_W | New conversion result, straight binary |
| fmt_sb_i | input | 1 | 1 = straight binary, 0 = two's complement |
| tag_i | input | 1 | Level driven on the data line between bursts |
| dclk_o | output | 1 | Self-generated data clock |
| dout_o | output | 1 | Serial data |
| done_o | output | 1 | One-cycle pulse after the last bit |
| busy_o | output | 1 | High from the accepted strobe to the end of the burst |

## Verification
A wrong wait or half-period count shows on the first burst: its first rising edge, and the spacing between edges, land on a different cycle from START_DLY and 2*HALF_PER. A wrong edge counter changes the number of pulses, which moves done_o by at least one whole clock period and leaves the word short or long. A shifter that moves on the wrong edge, or that loads the wrong word, corrupts the very first bit sampled at a rising edge. A tag register that is captured at the wrong moment shows on the data line the cycle after done_o.

// File: rtl/intclk_result_tx_pkg.sv
package intclk_result_tx_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_WAIT = 2'd1,
      ST_SEND = 2'd2
   } tx_state_e;
endpackage

// File: rtl/intclk_result_tx_timer.sv
module intclk_result_tx_timer
   import intclk_result_tx_pkg::*;
#(
   parameter int WORD_W    = 16,
   parameter int START_DLY = 34,
   parameter int HALF_PER  = 7
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   output logic accept_o,
   output logic fall_o,
   output logic sclk_o,
   output logic active_o,
   output logic done_o
);
   localparam int DLY_W = $clog2(START_DLY + 1);
   localparam int PH_W  = $clog2(HALF_PER + 1);
   localparam int CNT_W = $clog2(WORD_W + 1);
   localparam logic [DLY_W-1:0] DLY_LAST = DLY_W'(START_DLY - 1);
   localparam logic [PH_W-1:0]  PH_LAST  = PH_W'(HALF_PER - 1);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WORD_W - 1);

   tx_state_e        state_q;
   logic [DLY_W-1:0] dly_q;
   logic [PH_W-1:0]  ph_q;
   logic [CNT_W-1:0] cnt_q;
   logic             sclk_q;
   logic             done_q;

   assign accept_o = start_i && (state_q == ST_IDLE);
   assign fall_o   = (state_q == ST_SEND) && (ph_q == '0) && sclk_q;
   assign sclk_o   = sclk_q;
   assign active_o = (state_q != ST_IDLE);
   assign done_o   = done_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         dly_q   <= '0;
         ph_q    <= '0;
         cnt_q   <= '0;
         sclk_q  <= 1'b0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (start_i) begin
                  state_q <= ST_WAIT;
                  dly_q   <= DLY_LAST;
               end
            end
            ST_WAIT: begin
               if (dly_q == '0) begin
                  state_q <= ST_SEND;
                  sclk_q  <= 1'b1;
                  ph_q    <= PH_LAST;
                  cnt_q   <= '0;
               end else begin
                  dly_q <= dly_q - 1'b1;
               end
            end
            ST_SEND: begin
               if (ph_q == '0) begin
                  ph_q   <= PH_LAST;
                  sclk_q <= ~sclk_q;
                  if (sclk_q) begin
                     cnt_q <= cnt_q + 1'b1;
                     if (cnt_q == CNT_LAST) begin
                        state_q <= ST_IDLE;
                        done_q  <= 1'b1;
                     end
                  end
               end else begin
                  ph_q <= ph_q - 1'b1;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/intclk_result_tx_shifter.sv
module intclk_result_tx_shifter #(
   parameter int WORD_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              res_load_i,
   input  logic [WORD_W-1:0] res_word_i,
   input  logic              fmt_sb_i,
   input  logic              tag_i,
   input  logic              load_i,
   input  logic              shift_i,
   input  logic              active_i,
   output logic              sdata_o
);
   logic [WORD_W-1:0] hold_q;
   logic [WORD_W-1:0] coded;
   logic [WORD_W-1:0] shreg_q;
   logic              tag_q;

   // Output coding: only the top bit depends on the format select.
   for (genvar b = 0; b < WORD_W; b++) begin : g_code
      if (b == WORD_W - 1) begin : g_top
         assign coded[b] = hold_q[b] ^ ~fmt_sb_i;
      end else begin : g_pass
         assign coded[b] = hold_q[b];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hold_q  <= '0;
         shreg_q <= '0;
         tag_q   <= 1'b0;
      end else begin
         if (res_load_i) hold_q <= res_word_i;
         if (load_i) begin
            shreg_q <= coded;
            tag_q   <= tag_i;
         end else if (shift_i) begin
            shreg_q <= {shreg_q[WORD_W-2:0], 1'b0};
         end
      end
   end

   assign sdata_o = active_i ? shreg_q[WORD_W-1] : tag_q;
endmodule

// File: rtl/intclk_result_tx.sv
module intclk_result_tx #(
   parameter int WORD_W    = 16,
   parameter int START_DLY = 34,
   parameter int HALF_PER  = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              conv_start_i,
   input  logic              res_load_i,
   input  logic [WORD_W-1:0] res_word_i,
   input  logic              fmt_sb_i,
   input  logic              tag_i,
   output logic              dclk_o,
   output logic              dout_o,
   output logic              done_o,
   output logic              busy_o
);
   if (WORD_W < 2) begin : g_bad_w
      $error("WORD_W must be at least 2");
   end
   if (START_DLY < 1) begin : g_bad_d
      $error("START_DLY must be at least 1");
   end
   if (HALF_PER < 1) begin : g_bad_h
      $error("HALF_PER must be at least 1");
   end

   logic accept;
   logic fall;
   logic active;

   intclk_result_tx_timer #(
      .WORD_W(WORD_W), .START_DLY(START_DLY), .HALF_PER(HALF_PER)
   ) u_timer (
      .clk(clk), .rst_n(rst_n), .start_i(conv_start_i),
      .accept_o(accept), .fall_o(fall), .sclk_o(dclk_o),
      .active_o(active), .done_o(done_o)
   );

   intclk_result_tx_shifter #(.WORD_W(WORD_W)) u_shift (
      .clk(clk), .rst_n(rst_n), .res_load_i(res_load_i),
      .res_word_i(res_word_i), .fmt_sb_i(fmt_sb_i), .tag_i(tag_i),
      .load_i(accept), .shift_i(fall), .active_i(active),
      .sdata_o(dout_o)
   );

   assign busy_o = active;
endmodule

// File: rtl/intclk_result_tx_chk.sv
module intclk_result_tx_chk #(
   parameter int WORD_W = 16
) (
   input logic clk,
   input logic rst_n,
   input logic sclk,
   input logic sdata,
   input logic done,
   input logic active
);
   localparam int RC_W = $clog2(WORD_W + 2);

   logic            sclk_d;
   logic            act_d;
   logic [RC_W-1:0] rise_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sclk_d   <= 1'b0;
         act_d    <= 1'b0;
         rise_cnt <= '0;
      end else begin
         sclk_d <= sclk;
         act_d  <= active;
         if (active && !act_d) rise_cnt <= '0;
         else if (sclk && !sclk_d) rise_cnt <= rise_cnt + 1'b1;
      end
   end

   assert_idle_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !active |-> !sclk);
   assert_rise_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
      rise_cnt <= RC_W'(WORD_W));
   assert_done_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> rise_cnt == RC_W'(WORD_W));
   assert_high_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (sclk && sclk_d) |-> $stable(sdata));
   assert_park_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!active && !act_d) |-> $stable(sdata));
   assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   assert_done_ends_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!active && act_d && !sclk));
endmodule

bind intclk_result_tx intclk_result_tx_chk #(.WORD_W(WORD_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .sclk(dclk_o), .sdata(dout_o),
   .done(done_o), .active(busy_o)
);

// File: tb/tb_intclk_result_tx.sv
module tb_intclk_result_tx;
   localparam int W = 16;
   localparam int D = 5;
   localparam int H = 2;
   localparam int DONE_N = D + (2 * W - 1) * H;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start = 1'b0;
   logic         ld = 1'b0;
   logic [W-1:0] word = '0;
   logic         sb = 1'b1;
   logic         tag = 1'b0;
   logic         sclk, sdata, done, busy;

   int tests = 0;
   int fails = 0;
   bit finished = 0;

   always #4 clk = ~clk;

   intclk_result_tx #(.WORD_W(W), .START_DLY(D), .HALF_PER(H)) dut (
      .clk(clk), .rst_n(rst_n), .conv_start_i(start), .res_load_i(ld),
      .res_word_i(word), .fmt_sb_i(sb), .tag_i(tag), .dclk_o(sclk),
      .dout_o(sdata), .done_o(done), .busy_o(busy)
   );

   // held word, format, tag, expected serial word
   localparam logic [33:0] VEC [6] = '{
      {16'h8000, 1'b0, 1'b0, 16'h0000},
      {16'hFFFF, 1'b0, 1'b1, 16'h7FFF},
      {16'h0000, 1'b0, 1'b0, 16'h8000},
      {16'hA5C3, 1'b1, 1'b1, 16'hA5C3},
      {16'h1234, 1'b0, 1'b1, 16'h9234},
      {16'h7FFF, 1'b1, 1'b0, 16'h7FFF}
   };

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic load_word(input logic [W-1:0] w);
      @(negedge clk); ld = 1'b1; word = w;
      @(negedge clk); ld = 1'b0;
   endtask

   // Runs one burst; disturb pulses start, a load and flips tag/format mid-burst.
   task automatic run_burst(input logic [W-1:0] exp_w, input logic exp_tag,
                            input bit disturb, input logic [W-1:0] dist_w,
                            input bit load_with_start, input logic [W-1:0] lw);
      int first_hi = -1, rises = 0, done_at = -1;
      bit spacing_ok = 1, stable_ok = 1, setup_ok = 1;
      bit prev_s = 0, prev_d = 0, cur = 0;
      logic [W-1:0] got = '0;
      logic tag_keep = tag, sb_keep = sb;
      @(negedge clk); start = 1'b1;
      if (load_with_start) begin ld = 1'b1; word = lw; end
      @(negedge clk); start = 1'b0; ld = 1'b0;
      for (int n = 0; n < 400; n++) begin
         if (sclk && !prev_s) begin
            rises++;
            got = {got[W-2:0], sdata};
            cur = sdata;
            if (sdata != prev_d) setup_ok = 0;
            if (rises == 1) first_hi = n;
            else if (n != first_hi + 2 * (rises - 1) * H) spacing_ok = 0;
         end else if (sclk && sdata != cur) begin
            stable_ok = 0;
         end
         if (done) begin done_at = n; break; end
         if (disturb && n == D + 4) begin
            start = 1'b1; ld = 1'b1; word = dist_w; tag = ~tag; sb = ~sb;
         end
         if (disturb && n == D + 5) begin start = 1'b0; ld = 1'b0; end
         prev_s = sclk; prev_d = sdata;
         @(negedge clk);
      end
      check(got == exp_w, "R4 word", got, exp_w);
      check(setup_ok && stable_ok, "R4 bit stability", {setup_ok, stable_ok}, 2'b11);
      check(rises == W, "R2 pulse count", rises, W);
      check(first_hi == D && spacing_ok, "R3 first edge and spacing", first_hi, D);
      check(done_at == DONE_N && !busy, "R9 done position", done_at, DONE_N);
      @(negedge clk);
      check(!done, "R9 done width", done, 0);
      check(sdata == exp_tag, "R5 parked tag", sdata, exp_tag);
      if (disturb) begin
         tag = tag_keep; sb = sb_keep;
      end
   endtask

   initial begin
      #(8 * 200000);
      if (!finished) begin
         fails++; tests++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check({sclk, sdata, done, busy} == 4'b0, "R1 reset outputs",
            {sclk, sdata, done, busy}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check({sclk, sdata, done, busy} == 4'b0, "R1 after reset",
            {sclk, sdata, done, busy}, 0);
      // R1: held word is zero after reset -> straight binary sends 0x0000
      run_burst(16'h0000, 1'b0, 1'b0, '0, 1'b0, '0);

      foreach (VEC[i]) begin
         load_word(VEC[i][33:18]);
         sb = VEC[i][17]; tag = VEC[i][16];
         run_burst(VEC[i][15:0], VEC[i][16], 1'b0, '0, 1'b0, '0);
         check(VEC[i][15:0] == (VEC[i][17] ? VEC[i][33:18]
               : {~VEC[i][33], VEC[i][32:18]}), "R6 table", VEC[i][15:0], 0);
      end

      // R5: tag changes between bursts leave the parked level alone; R10 clock low
      begin
         bit park_ok = 1, clk_ok = 1;
         logic parked = sdata;
         for (int k = 0; k < 20; k++) begin
            tag = k[0];
            @(negedge clk);
            if (sdata != parked) park_ok = 0;
            if (sclk) clk_ok = 0;
         end
         check(park_ok, "R5 tag change between bursts", sdata, parked);
         check(clk_ok, "R10 idle clock low", sclk, 0);
      end

      // R7 and R8 and R6 sampling: disturbances mid-burst do not affect it
      load_word(16'h3C5A);
      sb = 1'b1; tag = 1'b1;
      run_burst(16'h3C5A, 1'b1, 1'b1, 16'hC001, 1'b0, '0);
      begin
         bit quiet = 1;
         for (int k = 0; k < D + 4 * H; k++) begin
            @(negedge clk);
            if (sclk || busy) quiet = 0;
         end
         check(quiet, "R8 ignored start leaves no burst", {sclk, busy}, 0);
      end
      // R7: the mid-burst load is sent by the next burst
      run_burst(16'hC001, 1'b1, 1'b0, '0, 1'b0, '0);

      // R7: load on the strobe edge goes to the following burst
      sb = 1'b0; tag = 1'b0;
      run_burst(16'h4001, 1'b0, 1'b0, '0, 1'b1, 16'h0F0F);
      run_burst(16'h8F0F, 1'b0, 1'b0, '0, 1'b0, '0);

      finished = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule